// File: doc/BRIEF.md
# Sectored NOR-Style Flash Array Model

This block is a synthesizable, on-chip stand-in for a sectored NOR-style nonvolatile memory. It is built from a register array. A single request port accepts five commands: read a word, program a word, erase a sector, lock a sector and unlock a sector. Programming behaves like real floating-gate cells. The stored word becomes the old contents ANDed with the new data, so a bit can only go from 1 to 0. The only way back to 1 is to erase the whole sector that holds the word.

A sector erase walks through the sector one word per clock and holds `busy` high for the whole sweep. While `busy` is high, every request is refused with a one-cycle `rej_busy` pulse and has no effect. Each sector has a lock bit. A program or erase aimed at a locked sector is dropped and flagged with `rej_prot`. Reads of a locked sector are still served. After reset the whole array reads as all ones and no sector is locked.

Top module: `nor_sector_array`

## Requirements
- R1: After reset every word reads as all ones, `busy` is 0 and no sector is locked.
- R2: A read (op code 0) accepted at a clock edge gives `rd_valid`=1 and the word on `rd_data` after that edge, one cycle of latency. `rd_valid` is 0 in every other cycle.
- R3: A program (op code 1) to an unlocked sector stores the old word ANDed with `req_wdata`. A read issued in the next cycle returns the new value.
- R4: Programming a 1 over a stored 0 leaves that bit at 0.
- R5: An erase (op code 2) of an unlocked sector sets every word of that sector to all ones and leaves every other sector unchanged.
- R6: `busy` rises in the cycle after an accepted erase and stays high for exactly SECTOR_WORDS cycles.
- R7: Any request made while `busy` is 1 gives a `rej_busy` pulse in the next cycle. It produces no `rd_valid` and leaves the array and the lock bits unchanged.
- R8: Lock (op code 3) sets the lock bit of the addressed sector. A program or erase to a locked sector changes nothing, does not raise `busy`, and gives a `rej_prot` pulse in the next cycle.
- R9: Unlock (op code 4) clears the lock bit of the addressed sector, after which program and erase work on it again.
- R10: Reads of a locked sector are served normally.
- R11: Op codes 5 to 7 have no effect on the array, the lock bits or any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Command: 0 read, 1 program, 2 erase, 3 lock, 4 unlock |
| req_addr | input | ADDR_W | Word address: sector index in the upper bits, word offset in the lower bits |
| req_wdata | input | DATA_W | Program data |
| busy | output | 1 | Sector erase sweep in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| rej_busy | output | 1 | Previous-cycle request refused because of busy |
| rej_prot | output | 1 | Previous-cycle program or erase dropped because the sector is locked |

## Verification
The bench builds the block with DATA_W=16, SECTOR_WORDS=8 and SECTORS=4, so the array has 32 words. With these sizes the bench can read back every word of every sector after each erase and confirm the neighbouring sectors are untouched. An 8-cycle sweep is long enough to place refused requests both at the start and in the middle of `busy`. Sixteen-bit words let the AND behaviour be checked with bit patterns that overlap only in part.

// File: rtl/nsa_pkg.sv
package nsa_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_LOCK   = 3'd3,
        OP_UNLOCK = 3'd4
    } op_e;

    typedef enum logic {
        SW_IDLE  = 1'b0,
        SW_SWEEP = 1'b1
    } sweep_e;

    typedef struct packed {
        logic rd;
        logic prog;
        logic erase;
        logic lock;
        logic unlock;
    } cmd_t;

    function automatic cmd_t decode_op(input logic [2:0] code);
        cmd_t c;
        c        = '0;
        c.rd     = (code == OP_READ);
        c.prog   = (code == OP_PROG);
        c.erase  = (code == OP_ERASE);
        c.lock   = (code == OP_LOCK);
        c.unlock = (code == OP_UNLOCK);
        return c;
    endfunction

    function automatic logic alters_cells(input cmd_t c);
        return c.prog | c.erase;
    endfunction

endpackage

// File: rtl/nsa_store.sv
module nsa_store #(
    parameter int DATA_W = 8,
    parameter int WORDS  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
            end
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= mem[rd_addr];
            end
            if (clr_en) begin
                mem[clr_addr] <= '1;
            end else if (prog_en) begin
                mem[prog_addr] <= mem[prog_addr] & prog_data;
            end
        end
    end

    AST_ERASE_ONES: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> (mem[$past(clr_addr)] == '1)); // R5

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (prog_en && !clr_en) |=>
            ((mem[$past(prog_addr)] & ~$past(mem[prog_addr])) == '0)); // R4

    AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(prog_en && clr_en)); // R7

endmodule

// File: rtl/nsa_eraser.sv
module nsa_eraser
    import nsa_pkg::*;
#(
    parameter int SECTOR_WORDS = 16,
    parameter int SEC_W        = 2,
    parameter int OFF_W        = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [SEC_W-1:0]       start_sector,
    output logic                   busy,
    output logic                   clr_en,
    output logic [SEC_W+OFF_W-1:0] clr_addr
);

    localparam logic [OFF_W-1:0] LAST = OFF_W'(SECTOR_WORDS - 1);

    sweep_e           state;
    logic [OFF_W-1:0] cnt;
    logic [SEC_W-1:0] sector;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SW_IDLE;
            cnt    <= '0;
            sector <= '0;
        end else begin
            case (state)
                SW_IDLE: begin
                    if (start) begin
                        state  <= SW_SWEEP;
                        cnt    <= '0;
                        sector <= start_sector;
                    end
                end
                SW_SWEEP: begin
                    if (cnt == LAST) begin
                        state <= SW_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    assign busy     = (state == SW_SWEEP);
    assign clr_en   = busy;
    assign clr_addr = {sector, cnt};

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (state == SW_IDLE)); // R7

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R6

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST) |=> !busy); // R6

endmodule

// File: rtl/nsa_protect.sv
module nsa_protect #(
    parameter int SECTORS = 4,
    parameter int SEC_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_en,
    input  logic             unlock_en,
    input  logic [SEC_W-1:0] sel,
    output logic             hit
);

    logic [SECTORS-1:0] bits;

    for (genvar s = 0; s < SECTORS; s++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[s] <= 1'b0;
            end else if (32'(sel) == s) begin
                if (lock_en) begin
                    bits[s] <= 1'b1;
                end else if (unlock_en) begin
                    bits[s] <= 1'b0;
                end
            end
        end
    end

    assign hit = bits[sel];

    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (rst)
        lock_en |=> bits[$past(sel)]); // R8

    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (unlock_en && !lock_en) |=> !bits[$past(sel)]); // R9

endmodule

// File: rtl/nor_sector_array.sv
module nor_sector_array
    import nsa_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SECTOR_WORDS = 16,
    parameter int SECTORS      = 4,
    localparam int OFF_W       = $clog2(SECTOR_WORDS),
    localparam int SEC_W       = (SECTORS > 1) ? $clog2(SECTORS) : 1,
    localparam int ADDR_W      = SEC_W + OFF_W,
    localparam int WORDS       = SECTORS * SECTOR_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rej_busy,
    output logic              rej_prot
);

    cmd_t              cmd;
    logic              accept;
    logic              locked;
    logic [SEC_W-1:0]  req_sector;
    logic              rd_en;
    logic              prog_en;
    logic              erase_go;
    logic              clr_en;
    logic [ADDR_W-1:0] clr_addr;

    assign cmd        = decode_op(req_op);
    assign req_sector = req_addr[ADDR_W-1:OFF_W];
    assign accept     = req_valid && !busy;
    assign rd_en      = accept && cmd.rd;
    assign prog_en    = accept && cmd.prog && !locked;
    assign erase_go   = accept && cmd.erase && !locked;

    nsa_protect #(
        .SECTORS (SECTORS),
        .SEC_W   (SEC_W)
    ) prot_i (
        .clk       (clk),
        .rst       (rst),
        .lock_en   (accept && cmd.lock),
        .unlock_en (accept && cmd.unlock),
        .sel       (req_sector),
        .hit       (locked)
    );

    nsa_eraser #(
        .SECTOR_WORDS (SECTOR_WORDS),
        .SEC_W        (SEC_W),
        .OFF_W        (OFF_W)
    ) sweep_i (
        .clk          (clk),
        .rst          (rst),
        .start        (erase_go),
        .start_sector (req_sector),
        .busy         (busy),
        .clr_en       (clr_en),
        .clr_addr     (clr_addr)
    );

    nsa_store #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .ADDR_W (ADDR_W)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .prog_en   (prog_en),
        .prog_addr (req_addr),
        .prog_data (req_wdata),
        .clr_en    (clr_en),
        .clr_addr  (clr_addr),
        .rd_en     (rd_en),
        .rd_addr   (req_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rej_busy <= 1'b0;
            rej_prot <= 1'b0;
        end else begin
            rej_busy <= req_valid && busy;
            rej_prot <= accept && alters_cells(cmd) && locked;
        end
    end

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> (rej_busy && !rd_valid)); // R7

    AST_PROT_NO_SWEEP: assert property (@(posedge clk) disable iff (rst)
        rej_prot |-> !busy); // R8

    AST_READ_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(busy)); // R2

    AST_REJECT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rej_busy && rej_prot)); // R7

endmodule

// File: tb/nor_sector_array_tb_top.sv
module nor_sector_array_tb_top;

    localparam int DW  = 16;
    localparam int SW  = 8;
    localparam int NS  = 4;
    localparam int AW  = 5;
    localparam int NW  = SW * NS;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [2:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          busy, rd_valid, rej_busy, rej_prot;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] model [NW];

    always #4 clk = ~clk;

    nor_sector_array #(.DATA_W(DW), .SECTOR_WORDS(SW), .SECTORS(NS)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .rej_busy(rej_busy),
        .rej_prot(rej_prot)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, accepted at next posedge, outputs sampled at following negedge
    task automatic issue(input logic [2:0] op, input int addr, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = AW'(addr);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_chk(input int addr, input logic [DW-1:0] exp, input string req);
        issue(3'd0, addr, '0);
        check(rd_valid === 1'b1, req, int'(rd_valid), 1);
        check(rd_data === exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < NW; a++) read_chk(a, model[a], req);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic prog(input int addr, input logic [DW-1:0] d);
        issue(3'd1, addr, d);
        model[addr] = model[addr] & d;
    endtask

    task automatic t_reset();
        check(busy === 1'b0, "R1 busy", int'(busy), 0);
        check(rd_valid === 1'b0, "R2 idle rd_valid", int'(rd_valid), 0);
        read_all("R1 erased");
        prog(3, 16'h0F0F);
        check(rej_prot === 1'b0, "R1 unlocked", int'(rej_prot), 0);
    endtask

    task automatic t_prog();
        prog(9, 16'hA5C3);
        read_chk(9, model[9], "R3 program");
        prog(9, 16'hF00F);
        read_chk(9, 16'hA003, "R3 and-merge");
        prog(9, 16'hFFFF);
        read_chk(9, 16'hA003, "R4 no set");
        prog(20, 16'h1234);
        prog(31, 16'h8001);
        read_all("R3 all words");
    endtask

    task automatic t_erase();
        int hi = 0;
        prog(8, 16'h0000);
        prog(15, 16'h00FF);
        issue(3'd2, 12, '0);
        while (busy === 1'b1 && hi < 50) begin
            hi++;
            @(negedge clk);
        end
        check(hi == SW, "R6 busy length", hi, SW);
        for (int a = 8; a < 16; a++) model[a] = '1;
        read_all("R5 erase sector");
    endtask

    task automatic t_refuse();
        prog(2, 16'h7777);
        issue(3'd2, 17, '0);
        check(busy === 1'b1, "R6 busy rises", int'(busy), 1);
        issue(3'd1, 2, 16'h0000);
        check(rej_busy === 1'b1, "R7 refuse prog", int'(rej_busy), 1);
        issue(3'd0, 2, '0);
        check(rej_busy === 1'b1, "R7 refuse read", int'(rej_busy), 1);
        check(rd_valid === 1'b0, "R7 no read data", int'(rd_valid), 0);
        issue(3'd3, 3, '0);
        check(rej_busy === 1'b1, "R7 refuse lock", int'(rej_busy), 1);
        wait_idle();
        for (int a = 16; a < 24; a++) model[a] = '1;
        read_all("R7 unchanged");
        prog(3, 16'h0000);
        check(rej_prot === 1'b0, "R7 lock not taken", int'(rej_prot), 0);
    endtask

    task automatic t_protect();
        prog(25, 16'h3C3C);
        issue(3'd3, 26, '0);
        issue(3'd1, 25, 16'h0000);
        check(rej_prot === 1'b1, "R8 prog dropped flag", int'(rej_prot), 1);
        issue(3'd2, 24, '0);
        check(rej_prot === 1'b1, "R8 erase dropped flag", int'(rej_prot), 1);
        check(busy === 1'b0, "R8 no busy", int'(busy), 0);
        read_chk(25, 16'h3C3C, "R10 read locked");
        read_all("R8 locked unchanged");
        issue(3'd4, 30, '0);
        issue(3'd2, 24, '0);
        check(rej_prot === 1'b0, "R9 no flag", int'(rej_prot), 0);
        check(busy === 1'b1, "R9 erase runs", int'(busy), 1);
        wait_idle();
        for (int a = 24; a < 32; a++) model[a] = '1;
        read_all("R9 erased after unlock");
    endtask

    task automatic t_badop();
        for (int c = 5; c < 8; c++) begin
            issue(3'(c), 4, 16'h0000);
            check(!rd_valid && !busy && !rej_busy && !rej_prot, "R11 no output",
                  int'({rd_valid, busy, rej_busy, rej_prot}), 0);
        end
        prog(4, 16'hFF00);
        check(rej_prot === 1'b0, "R11 lock untouched", int'(rej_prot), 0);
        read_all("R11 array intact");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        req_valid = 1'b0;
        req_op    = '0;
        req_addr  = '0;
        req_wdata = '0;
        rst       = 1'b1;
        for (int a = 0; a < NW; a++) model[a] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prog();
        t_erase();
        t_refuse();
        t_protect();
        t_badop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule